// File: doc/BRIEF.md
# USB Device Enumeration State Tracker

This block follows a USB device-side function through its enumeration and shows where it stands as a read-only 8-bit status byte. An endpoint-0 request engine feeds it events: a bus reset pulse, and a one-cycle completion strobe for each standard request, together with the request code, the descriptor type and the low configuration bytes of wValue. The block's own asynchronous active-low reset acts as the controller reset.

From these events the block keeps three enumeration flags and samples one firmware control bit. Its outputs tell the endpoint logic three things: whether any transaction may be answered, whether endpoints other than endpoint 0 may be reached, and whether endpoint 0 may send packets larger than 8 bytes. A further output tells the request engine to route configuration-descriptor reads to the CPU. A SET_CONFIGURATION value that the block cannot accept raises a one-cycle stall request.

The status byte uses these bit positions: bit 6 is the CPU-routing control, bit 4 is the large-packet flag, bit 3 is the default-state flag and bit 2 is the configured flag. All other bits read 0. Request codes follow the USB standard: GET_DESCRIPTOR is 06h, SET_CONFIGURATION is 09h, and descriptor type 01h is Device.

Top module: `usb_enum_tracker`

## Requirements
- R1: After the controller reset (rst_n low), status_reg reads 00h, and respond_en, nonzero_ep_en, ep0_use_max_pkt and req_stall are all 0.
- R2: A bus_reset pulse sets status bit 3 (default-state) one clock later, and respond_en then follows that bit.
- R3: A bus_reset pulse clears status bit 2 (configured) one clock later.
- R4: A bus_reset pulse leaves status bit 4 (large-packet) unchanged.
- R5: A completion of GET_DESCRIPTOR (code 06h) with descriptor type 01h sets status bit 4 one clock later. ep0_use_max_pkt is bit 4 AND (EP0_MAX_PKT is not 8).
- R6: A completion of SET_CONFIGURATION (code 09h) with wValue[7:0]=1 sets bit 2, and with wValue[7:0]=0 clears it, one clock later. wValue[15:8] is ignored. nonzero_ep_en follows bit 2.
- R7: A SET_CONFIGURATION completion with wValue[7:0] greater than 1 leaves bit 2 unchanged and drives req_stall high for exactly one cycle, one clock after the strobe.
- R8: When bus_reset and req_done are high in the same cycle, the bus reset wins. The request has no effect on the flags and raises no stall.
- R9: While bit 3 is 0, request completions change no flag and raise no stall.
- R10: Status bit 6 and cfg_desc_to_cpu show the value of the input cfg_desc_cpu_ctl one clock after it is applied.
- R11: Bits 7, 5, 1 and 0 always read 0. Completions with other codes or descriptor types (for example GET_DESCRIPTOR type 02h) change no flag.
- R12: The controller reset clears every flag, including bit 4, which a bus reset cannot clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| bus_reset | input | 1 | One-cycle bus reset detected pulse |
| req_done | input | 1 | One-cycle pulse when a request's status stage completes normally |
| req_code | input | 8 | bRequest of the completed request |
| desc_type | input | 8 | Descriptor type of a GET_DESCRIPTOR request |
| w_value | input | 16 | wValue of the completed request |
| cfg_desc_cpu_ctl | input | 1 | Firmware control: 1 routes configuration-descriptor reads to the CPU |
| status_reg | output | 8 | Read-only enumeration status byte |
| respond_en | output | 1 | Endpoints may answer transactions |
| nonzero_ep_en | output | 1 | Endpoints other than 0 may be accessed |
| ep0_use_max_pkt | output | 1 | Endpoint 0 may transmit packets of its full maximum size |
| cfg_desc_to_cpu | output | 1 | Configuration-descriptor reads go to the CPU |
| req_stall | output | 1 | One-cycle pulse asking the request engine to STALL a bad configuration value |

## Verification
The hardest situation to reach is a bus reset that lands in the same cycle as a request completion. A normal engine never produces this overlap, so the bench drives both strobes together on one falling edge. It does this once with a valid configuration value and once with an invalid one. It then checks that the configured flag is clear and that no stall was raised. The bench also drives a second collision: a completion that arrives before the default state has been entered. This shows that flags cannot be set before the device is able to respond.

// File: rtl/usb_enum_pkg.sv
package usb_enum_pkg;
  localparam logic [7:0] REQ_GET_DESC  = 8'h06;
  localparam logic [7:0] REQ_SET_CFG   = 8'h09;
  localparam logic [7:0] DESC_DEVICE   = 8'h01;

  localparam int ST_CPU_BIT  = 6;
  localparam int ST_PKT_BIT  = 4;
  localparam int ST_DFLT_BIT = 3;
  localparam int ST_CONF_BIT = 2;

  typedef struct packed {
    logic pkt_set;
    logic conf_set;
    logic conf_clr;
    logic bad_cfg;
  } enum_evt_t;
endpackage

// File: rtl/usb_enum_req_decode.sv
module usb_enum_req_decode
  import usb_enum_pkg::*;
#(
  parameter int WVAL_W = 16,
  parameter int CFGV_W = 8
) (
  input  logic              req_done,
  input  logic [7:0]        req_code,
  input  logic [7:0]        desc_type,
  input  logic [WVAL_W-1:0] w_value,
  input  logic              bus_reset,
  input  logic              in_default,
  output enum_evt_t         evt
);
  logic              live;
  logic [CFGV_W-1:0] cfg_val;

  assign cfg_val = w_value[CFGV_W-1:0];
  // a bus reset overrides any completion in the same cycle
  assign live    = req_done && in_default && !bus_reset;

  always_comb begin
    evt = '0;
    if (live) begin
      if (req_code == REQ_GET_DESC && desc_type == DESC_DEVICE)
        evt.pkt_set = 1'b1;
      if (req_code == REQ_SET_CFG) begin
        if (cfg_val == CFGV_W'(1))      evt.conf_set = 1'b1;
        else if (cfg_val == '0)         evt.conf_clr = 1'b1;
        else                            evt.bad_cfg  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_enum_flags.sv
module usb_enum_flags
  import usb_enum_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_reset,
  input  enum_evt_t evt,
  input  logic      cpu_ctl_in,
  output logic      pkt_q,
  output logic      dflt_q,
  output logic      conf_q,
  output logic      stall_q,
  output logic      cpu_ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_q     <= 1'b0;
      dflt_q    <= 1'b0;
      conf_q    <= 1'b0;
      stall_q   <= 1'b0;
      cpu_ctl_q <= 1'b0;
    end else begin
      cpu_ctl_q <= cpu_ctl_in;
      stall_q   <= evt.bad_cfg;
      if (evt.pkt_set) pkt_q <= 1'b1;
      if (bus_reset) begin
        dflt_q <= 1'b1;
        conf_q <= 1'b0;
      end else if (evt.conf_set) begin
        conf_q <= 1'b1;
      end else if (evt.conf_clr) begin
        conf_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usb_enum_tracker.sv
module usb_enum_tracker
  import usb_enum_pkg::*;
#(
  parameter int EP0_MAX_PKT = 64,
  parameter int WVAL_W      = 16,
  parameter int CFGV_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              req_done,
  input  logic [7:0]        req_code,
  input  logic [7:0]        desc_type,
  input  logic [WVAL_W-1:0] w_value,
  input  logic              cfg_desc_cpu_ctl,
  output logic [7:0]        status_reg,
  output logic              respond_en,
  output logic              nonzero_ep_en,
  output logic              ep0_use_max_pkt,
  output logic              cfg_desc_to_cpu,
  output logic              req_stall
);
  enum_evt_t evt;
  logic pkt_q, dflt_q, conf_q, stall_q, cpu_q;

  usb_enum_req_decode #(.WVAL_W(WVAL_W), .CFGV_W(CFGV_W)) i_decode (
    .req_done  (req_done),
    .req_code  (req_code),
    .desc_type (desc_type),
    .w_value   (w_value),
    .bus_reset (bus_reset),
    .in_default(dflt_q),
    .evt       (evt)
  );

  usb_enum_flags i_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .evt       (evt),
    .cpu_ctl_in(cfg_desc_cpu_ctl),
    .pkt_q     (pkt_q),
    .dflt_q    (dflt_q),
    .conf_q    (conf_q),
    .stall_q   (stall_q),
    .cpu_ctl_q (cpu_q)
  );

  always_comb begin
    status_reg              = '0;
    status_reg[ST_CPU_BIT]  = cpu_q;
    status_reg[ST_PKT_BIT]  = pkt_q;
    status_reg[ST_DFLT_BIT] = dflt_q;
    status_reg[ST_CONF_BIT] = conf_q;
  end

  assign respond_en      = dflt_q;
  assign nonzero_ep_en   = conf_q;
  assign cfg_desc_to_cpu = cpu_q;
  assign req_stall       = stall_q;

  generate
    if (EP0_MAX_PKT == 8) begin : g_small_ep0
      assign ep0_use_max_pkt = 1'b0;
    end else begin : g_large_ep0
      assign ep0_use_max_pkt = pkt_q;
    end
  endgenerate
endmodule

// File: rtl/usb_enum_tracker_chk.sv
module usb_enum_tracker_chk #(
  parameter int WVAL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_reset,
  input logic              req_done,
  input logic [7:0]        req_code,
  input logic [WVAL_W-1:0] w_value,
  input logic [7:0]        status_reg,
  input logic              respond_en,
  input logic              nonzero_ep_en,
  input logic              req_stall
);
  assert_dflt_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (status_reg[3] && respond_en));

  assert_conf_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !status_reg[2]);

  assert_pkt_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (status_reg[4] == $past(status_reg[4])));

  assert_nz_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nonzero_ep_en |-> respond_en);

  assert_bad_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && !bus_reset && status_reg[3] && req_code == 8'h09 && w_value[7:0] > 8'd1)
      |=> (req_stall && $stable(status_reg[2])));

  assert_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !req_stall);

  assert_early_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !status_reg[3] |=> !req_stall);
endmodule

bind usb_enum_tracker usb_enum_tracker_chk #(.WVAL_W(WVAL_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_reset    (bus_reset),
  .req_done     (req_done),
  .req_code     (req_code),
  .w_value      (w_value),
  .status_reg   (status_reg),
  .respond_en   (respond_en),
  .nonzero_ep_en(nonzero_ep_en),
  .req_stall    (req_stall)
);

// File: tb/test_usb_enum_tracker.sv
module test_usb_enum_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        req_done = 1'b0;
  logic [7:0]  req_code = '0;
  logic [7:0]  desc_type = '0;
  logic [15:0] w_value = '0;
  logic        cfg_desc_cpu_ctl = 1'b0;
  logic [7:0]  status_reg;
  logic        respond_en, nonzero_ep_en, ep0_use_max_pkt, cfg_desc_to_cpu, req_stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_enum_tracker #(.EP0_MAX_PKT(64)) i_usb_enum_tracker (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_done(req_done),
    .req_code(req_code), .desc_type(desc_type), .w_value(w_value),
    .cfg_desc_cpu_ctl(cfg_desc_cpu_ctl), .status_reg(status_reg),
    .respond_en(respond_en), .nonzero_ep_en(nonzero_ep_en),
    .ep0_use_max_pkt(ep0_use_max_pkt), .cfg_desc_to_cpu(cfg_desc_to_cpu),
    .req_stall(req_stall)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one strobe cycle; outputs are checked at the following falling edge
  task automatic send(input logic br, input logic rd, input logic [7:0] code,
                      input logic [7:0] dt, input logic [15:0] wv);
    bus_reset = br; req_done = rd; req_code = code; desc_type = dt; w_value = wv;
    @(negedge clk);
    bus_reset = 1'b0; req_done = 1'b0; req_code = '0; desc_type = '0; w_value = '0;
  endtask

  task automatic t_reset;
    chk("R1 status", status_reg, 8'h00);
    chk("R1 outs", {respond_en, nonzero_ep_en, ep0_use_max_pkt, req_stall}, 4'b0000);
  endtask

  task automatic t_early;
    send(0, 1, 8'h09, 8'h00, 16'h0001);
    chk("R9 status", status_reg, 8'h00);
    send(0, 1, 8'h09, 8'h00, 16'h0003);
    chk("R9 stall", req_stall, 1'b0);
  endtask

  task automatic t_bus_reset;
    send(1, 0, 0, 0, 0);
    chk("R2 status", status_reg, 8'h08);
    chk("R2 respond_en", respond_en, 1'b1);
  endtask

  task automatic t_get_desc;
    send(0, 1, 8'h06, 8'h02, 16'h0200);
    chk("R11 cfg desc no effect", status_reg, 8'h08);
    send(0, 1, 8'h05, 8'h01, 16'h0001);
    chk("R11 other code no effect", status_reg, 8'h08);
    send(0, 1, 8'h06, 8'h01, 16'h0100);
    chk("R5 status", status_reg, 8'h18);
    chk("R5 max pkt", ep0_use_max_pkt, 1'b1);
  endtask

  task automatic t_set_cfg;
    send(0, 1, 8'h09, 8'h00, 16'hA501);
    chk("R6 set status", status_reg, 8'h1C);
    chk("R6 nonzero_ep_en", nonzero_ep_en, 1'b1);
    send(0, 1, 8'h09, 8'h00, 16'h0005);
    chk("R7 stall pulse", req_stall, 1'b1);
    chk("R7 conf kept", status_reg, 8'h1C);
    @(negedge clk);
    chk("R7 stall one cycle", req_stall, 1'b0);
    send(0, 1, 8'h09, 8'h00, 16'h0000);
    chk("R6 clr status", status_reg, 8'h18);
    chk("R6 nonzero off", nonzero_ep_en, 1'b0);
    send(0, 1, 8'h09, 8'h00, 16'h0001);
    send(1, 0, 0, 0, 0);
    chk("R3 conf cleared", status_reg[2], 1'b0);
    chk("R4 pkt kept", status_reg[4], 1'b1);
  endtask

  task automatic t_collision;
    send(1, 1, 8'h09, 8'h00, 16'h0001);
    chk("R8 conf not set", status_reg, 8'h18);
    send(1, 1, 8'h09, 8'h00, 16'h0007);
    chk("R8 no stall", req_stall, 1'b0);
  endtask

  task automatic t_cpu_ctl;
    cfg_desc_cpu_ctl = 1'b1;
    @(negedge clk);
    chk("R10 bit6 set", status_reg, 8'h58);
    chk("R10 route", cfg_desc_to_cpu, 1'b1);
    cfg_desc_cpu_ctl = 1'b0;
    @(negedge clk);
    chk("R10 bit6 clr", status_reg, 8'h18);
  endtask

  task automatic t_ctrl_reset;
    send(0, 1, 8'h09, 8'h00, 16'h0001);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 all clear", status_reg, 8'h00);
    chk("R11 unused bits", status_reg & 8'hA3, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_early;
    t_bus_reset;
    t_get_desc;
    t_set_cfg;
    t_collision;
    t_cpu_ctl;
    t_ctrl_reset;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule